// File: doc/BRIEF.md
# Privileged Trap Entry and Return Controller

This block sequences trap entry and trap return for a small 32-bit hart with user (U), supervisor (S) and machine (M) privilege levels. When the core raises a trap it supplies a cause code, a trap value, the PC of the faulting instruction and whether that instruction was compressed. The block picks the target level from the current privilege and saves the old interrupt-enable state and privilege in that level's status register. It loads the level's exception PC, cause and trap-value registers and switches privilege. It then emits a one-cycle redirect carrying the handler address, which comes from that level's trap-vector register.

On a supervisor or machine return request, the block restores privilege and the interrupt-enable bits and redirects to the saved exception PC. The same registers, plus a few plain storage registers for enables, delegation, scratch and translation, can be read and written by CSR address. The core's decode stage uses this path for its CSR instructions.

Top module: `trap_unit`

## Requirements
- R1: After reset every implemented CSR reads zero, the privilege level is S (encoding U=0, S=1, M=3), redirectValid is low, and a trap request held during reset has no effect.
- R2: A trap taken at privilege U or S targets S-mode. A trap taken at M targets M-mode. After the trap the privilege equals the target level.
- R3: On S-mode entry, sstatus bit 5 takes the old bit 1 and bit 1 is cleared. Bit 8 takes the low bit of the previous privilege. sepc, stval and scause are loaded with the trap PC, trap value and full cause.
- R4: On M-mode entry, mstatus bit 7 takes the old bit 3 and bit 3 is cleared. Bits 12:11 take the previous privilege. mepc, mtval and mcause are loaded with the trap PC, trap value and full cause.
- R5: When the target vector register's bits 1:0 hold any value other than 1, the redirect address is the vector with bits 1:0 cleared.
- R6: When the target vector register's bits 1:0 equal 1, the redirect address is the cleared base plus 4 times the cause with bit 31 cleared.
- R7: For an M-mode trap while mtvec is zero, mepc becomes the trap PC plus 2 if the instruction was compressed, or plus 4 otherwise, and the redirect goes to that new mepc.
- R8: A supervisor return sets privilege to {0, sstatus bit 8}, clears bit 8, ORs bit 5 into bit 1, sets bit 5 and redirects to sepc.
- R9: A machine return sets privilege to mstatus bits 12:11, clears those bits, ORs bit 7 into bit 3, sets bit 7 and redirects to mepc.
- R10: Every accepted trap or return completes in one clock edge. redirectValid is high for exactly the cycle after the request edge, and it stays low when no request is present.
- R11: Priority is trap over machine return over supervisor return. A CSR write presented in the same cycle as any trap or return is dropped.
- R12: The CSRs at 0x100, 0x104, 0x105, 0x106, 0x140, 0x141, 0x142, 0x143, 0x144, 0x180, 0x300, 0x302, 0x303, 0x305, 0x341, 0x342 and 0x343 hold full 32-bit values written and read by address.
- R13: A read or write to any other address raises csrIllegal. A read returns zero and a write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| trapReq | input | 1 | Take a trap this cycle |
| trapCause | input | 32 | Cause code, bit 31 marks an interrupt |
| trapValue | input | 32 | Faulting address or instruction bits |
| trapPc | input | 32 | PC of the trapping instruction |
| trapCompressed | input | 1 | Trapping instruction is 16 bits |
| sretReq | input | 1 | Supervisor return request |
| mretReq | input | 1 | Machine return request |
| csrAddr | input | 12 | CSR address |
| csrRdEn | input | 1 | CSR read strobe |
| csrWrEn | input | 1 | CSR write strobe |
| csrWrData | input | 32 | CSR write data |
| csrRdData | output | 32 | CSR read data, combinational |
| csrIllegal | output | 1 | Access to an unimplemented address |
| privLevel | output | 2 | Current privilege level |
| redirectValid | output | 1 | One-cycle redirect pulse |
| redirectPc | output | 32 | Redirect target address |

## Verification
The hardest state to reach from the ports is machine mode, because privilege leaves reset at S and any trap taken from S or U stays in S. The stimulus writes mstatus with bits 12:11 set to 3 and then issues a machine return, which lifts the hart to M. Only then can the zero-mtvec fallback with its compressed and full-width skips, machine vectoring, and the trap-versus-return priority cases be driven. Privilege U is reached the same way, by clearing sstatus bit 8 before a supervisor return.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int XLEN = 32;
  localparam int CSR_AW = 12;
  localparam int PRIV_W = 2;

  localparam logic [PRIV_W-1:0] PRIV_U = 2'd0;
  localparam logic [PRIV_W-1:0] PRIV_S = 2'd1;
  localparam logic [PRIV_W-1:0] PRIV_M = 2'd3;

  // status bit positions, decoded by the return logic
  localparam int SIE_BIT  = 1;
  localparam int MIE_BIT  = 3;
  localparam int SPIE_BIT = 5;
  localparam int MPIE_BIT = 7;
  localparam int SPP_BIT  = 8;
  localparam int MPP_LO   = 11;

  localparam logic [CSR_AW-1:0] A_SSTATUS  = 12'h100;
  localparam logic [CSR_AW-1:0] A_SIE      = 12'h104;
  localparam logic [CSR_AW-1:0] A_STVEC    = 12'h105;
  localparam logic [CSR_AW-1:0] A_SCNTEN   = 12'h106;
  localparam logic [CSR_AW-1:0] A_SSCRATCH = 12'h140;
  localparam logic [CSR_AW-1:0] A_SEPC     = 12'h141;
  localparam logic [CSR_AW-1:0] A_SCAUSE   = 12'h142;
  localparam logic [CSR_AW-1:0] A_STVAL    = 12'h143;
  localparam logic [CSR_AW-1:0] A_SIP      = 12'h144;
  localparam logic [CSR_AW-1:0] A_SATP     = 12'h180;
  localparam logic [CSR_AW-1:0] A_MSTATUS  = 12'h300;
  localparam logic [CSR_AW-1:0] A_MEDELEG  = 12'h302;
  localparam logic [CSR_AW-1:0] A_MIDELEG  = 12'h303;
  localparam logic [CSR_AW-1:0] A_MTVEC    = 12'h305;
  localparam logic [CSR_AW-1:0] A_MEPC     = 12'h341;
  localparam logic [CSR_AW-1:0] A_MCAUSE   = 12'h342;
  localparam logic [CSR_AW-1:0] A_MTVAL    = 12'h343;

  typedef struct packed {
    logic trapS;
    logic trapM;
    logic skipFault;
    logic doSret;
    logic doMret;
    logic csrWr;
  } ctrl_t;

  function automatic logic [XLEN-1:0] vecTarget(input logic [XLEN-1:0] vec,
                                                input logic [XLEN-1:0] cause);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] code;
    base = {vec[XLEN-1:2], 2'b00};
    code = cause & ~(XLEN'(1) << (XLEN-1));
    if (vec[1:0] == 2'b01) return base + (code << 2);
    return base;
  endfunction
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic              trapReq,
  input  logic              sretReq,
  input  logic              mretReq,
  input  logic              csrWrEn,
  input  logic              csrHit,
  input  logic [PRIV_W-1:0] priv,
  input  logic              mtvecZero,
  output ctrl_t             ctl
);
  logic lowPriv;
  logic anyEvent;

  always_comb begin
    lowPriv       = (priv <= PRIV_S);
    anyEvent      = trapReq | sretReq | mretReq;
    ctl.trapS     = trapReq & lowPriv;
    ctl.trapM     = trapReq & ~lowPriv;
    ctl.skipFault = trapReq & ~lowPriv & mtvecZero;
    ctl.doMret    = mretReq & ~trapReq;
    ctl.doSret    = sretReq & ~trapReq & ~mretReq;
    ctl.csrWr     = csrWrEn & csrHit & ~anyEvent;
  end
endmodule

// File: rtl/trap_regs.sv
module trap_regs
  import trap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [XLEN-1:0]   trapCause,
  input  logic [XLEN-1:0]   trapValue,
  input  logic [XLEN-1:0]   trapPc,
  input  logic              trapCompressed,
  input  logic [CSR_AW-1:0] csrAddr,
  input  logic [XLEN-1:0]   csrWrData,
  output logic [XLEN-1:0]   rdValue,
  output logic              csrHit,
  output logic              mtvecZero,
  output logic [PRIV_W-1:0] priv,
  output logic              redirectValid,
  output logic [XLEN-1:0]   redirectPc
);
  logic [XLEN-1:0] sstatus, sie, stvec, scnten, sscratch, sepc, scause, stval, sip, satp;
  logic [XLEN-1:0] mstatus, medeleg, mideleg, mtvec, mepc, mcause, mtval;
  logic [XLEN-1:0] skipPc;

  assign mtvecZero = (mtvec == '0);
  assign skipPc    = trapPc + (trapCompressed ? XLEN'(2) : XLEN'(4));

  always_comb begin
    csrHit  = 1'b1;
    rdValue = '0;
    case (csrAddr)
      A_SSTATUS:  rdValue = sstatus;
      A_SIE:      rdValue = sie;
      A_STVEC:    rdValue = stvec;
      A_SCNTEN:   rdValue = scnten;
      A_SSCRATCH: rdValue = sscratch;
      A_SEPC:     rdValue = sepc;
      A_SCAUSE:   rdValue = scause;
      A_STVAL:    rdValue = stval;
      A_SIP:      rdValue = sip;
      A_SATP:     rdValue = satp;
      A_MSTATUS:  rdValue = mstatus;
      A_MEDELEG:  rdValue = medeleg;
      A_MIDELEG:  rdValue = mideleg;
      A_MTVEC:    rdValue = mtvec;
      A_MEPC:     rdValue = mepc;
      A_MCAUSE:   rdValue = mcause;
      A_MTVAL:    rdValue = mtval;
      default:    csrHit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sstatus <= '0; sie <= '0; stvec <= '0; scnten <= '0; sscratch <= '0;
      sepc <= '0; scause <= '0; stval <= '0; sip <= '0; satp <= '0;
      mstatus <= '0; medeleg <= '0; mideleg <= '0; mtvec <= '0;
      mepc <= '0; mcause <= '0; mtval <= '0;
      priv <= PRIV_S;
      redirectValid <= 1'b0;
      redirectPc <= '0;
    end else begin
      redirectValid <= 1'b0;
      if (ctl.csrWr) begin
        case (csrAddr)
          A_SSTATUS:  sstatus  <= csrWrData;
          A_SIE:      sie      <= csrWrData;
          A_STVEC:    stvec    <= csrWrData;
          A_SCNTEN:   scnten   <= csrWrData;
          A_SSCRATCH: sscratch <= csrWrData;
          A_SEPC:     sepc     <= csrWrData;
          A_SCAUSE:   scause   <= csrWrData;
          A_STVAL:    stval    <= csrWrData;
          A_SIP:      sip      <= csrWrData;
          A_SATP:     satp     <= csrWrData;
          A_MSTATUS:  mstatus  <= csrWrData;
          A_MEDELEG:  medeleg  <= csrWrData;
          A_MIDELEG:  mideleg  <= csrWrData;
          A_MTVEC:    mtvec    <= csrWrData;
          A_MEPC:     mepc     <= csrWrData;
          A_MCAUSE:   mcause   <= csrWrData;
          A_MTVAL:    mtval    <= csrWrData;
          default: ;
        endcase
      end
      if (ctl.trapS) begin
        sstatus[SPIE_BIT] <= sstatus[SIE_BIT];
        sstatus[SIE_BIT]  <= 1'b0;
        sstatus[SPP_BIT]  <= priv[0];
        priv              <= PRIV_S;
        sepc              <= trapPc;
        stval             <= trapValue;
        scause            <= trapCause;
        redirectValid     <= 1'b1;
        redirectPc        <= vecTarget(stvec, trapCause);
      end
      if (ctl.trapM) begin
        mstatus[MPIE_BIT]         <= mstatus[MIE_BIT];
        mstatus[MIE_BIT]          <= 1'b0;
        mstatus[MPP_LO+:PRIV_W]   <= priv;
        priv                      <= PRIV_M;
        mepc                      <= ctl.skipFault ? skipPc : trapPc;
        mtval                     <= trapValue;
        mcause                    <= trapCause;
        redirectValid             <= 1'b1;
        redirectPc                <= ctl.skipFault ? skipPc : vecTarget(mtvec, trapCause);
      end
      if (ctl.doSret) begin
        priv              <= {1'b0, sstatus[SPP_BIT]};
        sstatus[SPP_BIT]  <= 1'b0;
        sstatus[SIE_BIT]  <= sstatus[SIE_BIT] | sstatus[SPIE_BIT];
        sstatus[SPIE_BIT] <= 1'b1;
        redirectValid     <= 1'b1;
        redirectPc        <= sepc;
      end
      if (ctl.doMret) begin
        priv                    <= mstatus[MPP_LO+:PRIV_W];
        mstatus[MPP_LO+:PRIV_W] <= '0;
        mstatus[MIE_BIT]        <= mstatus[MIE_BIT] | mstatus[MPIE_BIT];
        mstatus[MPIE_BIT]       <= 1'b1;
        redirectValid           <= 1'b1;
        redirectPc              <= mepc;
      end
    end
  end
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              trapReq,
  input  logic [XLEN-1:0]   trapCause,
  input  logic [XLEN-1:0]   trapValue,
  input  logic [XLEN-1:0]   trapPc,
  input  logic              trapCompressed,
  input  logic              sretReq,
  input  logic              mretReq,
  input  logic [CSR_AW-1:0] csrAddr,
  input  logic              csrRdEn,
  input  logic              csrWrEn,
  input  logic [XLEN-1:0]   csrWrData,
  output logic [XLEN-1:0]   csrRdData,
  output logic              csrIllegal,
  output logic [PRIV_W-1:0] privLevel,
  output logic              redirectValid,
  output logic [XLEN-1:0]   redirectPc
);
  ctrl_t           ctl;
  logic            csrHit;
  logic            mtvecZero;
  logic [XLEN-1:0] rdValue;

  trap_ctrl uCtrl (
    .trapReq(trapReq), .sretReq(sretReq), .mretReq(mretReq),
    .csrWrEn(csrWrEn), .csrHit(csrHit), .priv(privLevel),
    .mtvecZero(mtvecZero), .ctl(ctl)
  );

  trap_regs uRegs (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .trapCause(trapCause), .trapValue(trapValue), .trapPc(trapPc),
    .trapCompressed(trapCompressed), .csrAddr(csrAddr), .csrWrData(csrWrData),
    .rdValue(rdValue), .csrHit(csrHit), .mtvecZero(mtvecZero),
    .priv(privLevel), .redirectValid(redirectValid), .redirectPc(redirectPc)
  );

  assign csrRdData  = (csrRdEn && csrHit) ? rdValue : '0;
  assign csrIllegal = (csrRdEn | csrWrEn) & ~csrHit;
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk
  import trap_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              trapReq,
  input logic              sretReq,
  input logic              mretReq,
  input logic              csrRdEn,
  input logic [XLEN-1:0]   csrRdData,
  input logic              csrIllegal,
  input logic [PRIV_W-1:0] privLevel,
  input logic              redirectValid
);
  // R10
  redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq || sretReq || mretReq) |=> redirectValid);
  // R10
  redirect_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(trapReq || sretReq || mretReq) |=> !redirectValid);
  // R2
  s_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && privLevel <= PRIV_S) |=> (privLevel == PRIV_S));
  // R2
  m_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && privLevel == PRIV_M) |=> (privLevel == PRIV_M));
  // R8
  sret_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sretReq && !trapReq && !mretReq) |=> (privLevel[1] == 1'b0));
  // R13
  illegal_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrRdEn && csrIllegal) |-> (csrRdData == '0));
endmodule

bind trap_unit trap_unit_chk uChk (
  .clk(clk), .rstN(rstN), .trapReq(trapReq), .sretReq(sretReq),
  .mretReq(mretReq), .csrRdEn(csrRdEn), .csrRdData(csrRdData),
  .csrIllegal(csrIllegal), .privLevel(privLevel), .redirectValid(redirectValid)
);

// File: tb/trap_unit_test.sv
`timescale 1ns/1ps
module trap_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trapReq = 1'b0;
  logic [31:0] trapCause = '0;
  logic [31:0] trapValue = '0;
  logic [31:0] trapPc = '0;
  logic        trapCompressed = 1'b0;
  logic        sretReq = 1'b0;
  logic        mretReq = 1'b0;
  logic [11:0] csrAddr = '0;
  logic        csrRdEn = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [31:0] csrWrData = '0;
  logic [31:0] csrRdData;
  logic        csrIllegal;
  logic [1:0]  privLevel;
  logic        redirectValid;
  logic [31:0] redirectPc;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trap_unit uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic csrWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csrAddr = a; csrWrData = d; csrWrEn = 1'b1;
    @(negedge clk);
    csrWrEn = 1'b0;
  endtask

  task automatic csrRead(input logic [11:0] a, output logic [31:0] d, output logic ill);
    csrAddr = a; csrRdEn = 1'b1;
    #1;
    d = csrRdData; ill = csrIllegal;
    csrRdEn = 1'b0;
    #1;
  endtask

  task automatic checkCsr(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d; logic ill;
    csrRead(a, d, ill);
    check(tag, d, exp);
  endtask

  // drive one event for one cycle; return redirect seen after the edge
  task automatic pulse(input logic t, input logic s, input logic m,
                       input logic [31:0] cause, input logic [31:0] val,
                       input logic [31:0] pc, input logic comp,
                       output logic rv, output logic [31:0] rp);
    @(negedge clk);
    trapReq = t; sretReq = s; mretReq = m;
    trapCause = cause; trapValue = val; trapPc = pc; trapCompressed = comp;
    @(negedge clk);
    rv = redirectValid; rp = redirectPc;
    trapReq = 1'b0; sretReq = 1'b0; mretReq = 1'b0;
  endtask

  task automatic testReset();
    check("R1 priv after reset", 32'(privLevel), 32'd1);
    check("R1 redirectValid after reset", 32'(redirectValid), 32'd0);
    checkCsr("R1 sstatus reset", 12'h100, 32'h0);
    checkCsr("R1 mtvec reset", 12'h305, 32'h0);
    checkCsr("R1 mepc reset", 12'h341, 32'h0);
  endtask

  task automatic testSTrapDirect();
    logic rv; logic [31:0] rp;
    csrWrite(12'h100, 32'h2);
    csrWrite(12'h105, 32'h1000);
    pulse(1, 0, 0, 32'd4, 32'h0800_0003, 32'h200, 0, rv, rp);
    check("R10 redirectValid after S trap", 32'(rv), 32'd1);
    check("R5 S direct redirect", rp, 32'h1000);
    check("R2 priv after S trap", 32'(privLevel), 32'd1);
    checkCsr("R3 sstatus after entry", 12'h100, 32'h120);
    checkCsr("R3 sepc", 12'h141, 32'h200);
    checkCsr("R3 stval", 12'h143, 32'h0800_0003);
    checkCsr("R3 scause", 12'h142, 32'd4);
    @(negedge clk);
    check("R10 pulse ends", 32'(redirectValid), 32'd0);
  endtask

  task automatic testSret();
    logic rv; logic [31:0] rp;
    pulse(0, 1, 0, 0, 0, 0, 0, rv, rp);
    check("R8 sret redirect to sepc", rp, 32'h200);
    check("R8 sret priv from bit8=1", 32'(privLevel), 32'd1);
    checkCsr("R8 sstatus after sret", 12'h100, 32'h22);
    csrWrite(12'h100, 32'h20);
    pulse(0, 1, 0, 0, 0, 0, 0, rv, rp);
    check("R8 sret to user", 32'(privLevel), 32'd0);
    checkCsr("R8 sstatus SIE from SPIE", 12'h100, 32'h22);
  endtask

  task automatic testUTrapVectored();
    logic rv; logic [31:0] rp;
    csrWrite(12'h105, 32'h2001);
    pulse(1, 0, 0, 32'h8000_0005, 32'h0, 32'h300, 0, rv, rp);
    check("R6 vectored drops bit31", rp, 32'h2014);
    check("R2 user trap goes to S", 32'(privLevel), 32'd1);
    checkCsr("R3 sstatus from U", 12'h100, 32'h20);
    checkCsr("R3 scause full", 12'h142, 32'h8000_0005);
  endtask

  task automatic testEnterM();
    logic rv; logic [31:0] rp;
    csrWrite(12'h300, 32'h1808);
    csrWrite(12'h341, 32'h3000);
    pulse(0, 0, 1, 0, 0, 0, 0, rv, rp);
    check("R9 mret redirect to mepc", rp, 32'h3000);
    check("R9 mret priv from MPP", 32'(privLevel), 32'd3);
    checkCsr("R9 mstatus after mret", 12'h300, 32'h88);
  endtask

  task automatic testFallback();
    logic rv; logic [31:0] rp;
    pulse(1, 0, 0, 32'd3, 32'h400, 32'h400, 1, rv, rp);
    check("R7 compressed skip redirect", rp, 32'h402);
    check("R2 M trap stays M", 32'(privLevel), 32'd3);
    checkCsr("R7 mepc compressed", 12'h341, 32'h402);
    checkCsr("R4 mstatus after M entry", 12'h300, 32'h1880);
    checkCsr("R4 mcause", 12'h342, 32'd3);
    checkCsr("R4 mtval", 12'h343, 32'h400);
    pulse(1, 0, 0, 32'd4, 32'h0, 32'h500, 0, rv, rp);
    check("R7 full-width skip redirect", rp, 32'h504);
    checkCsr("R4 mstatus MIE 0 into MPIE", 12'h300, 32'h1800);
  endtask

  task automatic testMVector();
    logic rv; logic [31:0] rp;
    csrWrite(12'h305, 32'h4002);
    pulse(1, 0, 0, 32'd11, 32'h0, 32'h600, 0, rv, rp);
    check("R5 mode 2 treated as direct", rp, 32'h4000);
    checkCsr("R4 mepc no skip", 12'h341, 32'h600);
    csrWrite(12'h305, 32'h4001);
    pulse(1, 0, 0, 32'd11, 32'h0, 32'h600, 0, rv, rp);
    check("R6 M vectored cause 11", rp, 32'h402C);
  endtask

  task automatic testPriority();
    logic rv; logic [31:0] rp;
    csrWrite(12'h140, 32'h1111);
    @(negedge clk);
    trapReq = 1; mretReq = 1; trapCause = 32'd3; trapPc = 32'h700; trapCompressed = 0;
    csrAddr = 12'h140; csrWrData = 32'hDEAD; csrWrEn = 1;
    @(negedge clk);
    rv = redirectValid; rp = redirectPc;
    trapReq = 0; mretReq = 0; csrWrEn = 0;
    check("R11 trap beats mret", rp, 32'h400C);
    checkCsr("R11 csr write dropped with trap", 12'h140, 32'h1111);
    csrWrite(12'h141, 32'h6000);
    pulse(0, 1, 1, 0, 0, 0, 0, rv, rp);
    check("R11 mret beats sret", rp, 32'h700);
    check("R11 priv after mret", 32'(privLevel), 32'd3);
  endtask

  task automatic testIllegal();
    logic [31:0] d; logic ill;
    logic [11:0] addrs [17] = '{12'h100, 12'h104, 12'h105, 12'h106, 12'h140, 12'h141,
      12'h142, 12'h143, 12'h144, 12'h180, 12'h300, 12'h302, 12'h303, 12'h305,
      12'h341, 12'h342, 12'h343};
    @(negedge clk);
    csrAddr = 12'h7C0; csrWrData = 32'hFFFF_FFFF; csrWrEn = 1;
    #1;
    check("R13 illegal on write", 32'(csrIllegal), 32'd1);
    @(negedge clk);
    csrWrEn = 0;
    csrRead(12'h7C0, d, ill);
    check("R13 illegal read data", d, 32'h0);
    check("R13 illegal on read", 32'(ill), 32'd1);
    csrRead(12'h140, d, ill);
    check("R13 legal read not flagged", 32'(ill), 32'd0);
    check("R13 write changed nothing", d, 32'h1111);
    check("R13 priv unchanged", 32'(privLevel), 32'd3);
    for (int i = 0; i < 17; i++) begin
      csrWrite(addrs[i], 32'hA500_0000 + 32'(i));
    end
    for (int i = 0; i < 17; i++) begin
      checkCsr($sformatf("R12 readback %h", addrs[i]), addrs[i], 32'hA500_0000 + 32'(i));
    end
  endtask

  task automatic testResetMid();
    @(negedge clk);
    rstN = 0; trapReq = 1; trapCause = 32'd4; trapPc = 32'h900;
    repeat (2) @(negedge clk);
    trapReq = 0;
    rstN = 1;
    @(negedge clk);
    check("R1 priv after mid reset", 32'(privLevel), 32'd1);
    check("R1 no redirect after reset", 32'(redirectValid), 32'd0);
    checkCsr("R1 mepc cleared", 12'h341, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testSTrapDirect();
    testSret();
    testUTrapVectored();
    testEnterM();
    testFallback();
    testMVector();
    testPriority();
    testIllegal();
    testResetMid();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule